// File: doc/BRIEF.md
# Hysteretic Switch On/Off Timing Controller

This block produces the gate-enable for the low-side power switch of a converter that uses hysteretic peak-current control. An asynchronous request from the isolated feedback path turns the switch on. The secondary side ORs its voltage and current comparators onto this one line, so either comparator can ask for energy. An asynchronous peak-current trip turns the switch off. A maximum on-time counter turns it off as a backup if the trip never arrives. After every turn-off, a minimum off-time lockout holds the switch off. This lockout caps the switching frequency, forces a minimum energy packet per cycle and masks comparator noise right after switching.

Because the switch state is a set/reset latch, there is no fixed-frequency ramp, and the switching rate follows the load. Both time limits are counts of clock cycles, set by parameters. For example, 1000 and 126 cycles at 50 MHz give 20 µs and 2.52 µs. The isolated link pulls the request line high while the far side is unpowered, so a request that is held continuously must give repeated, bounded cycles. An enable input stops switching at once.

Top module: `hyst_gate_ctrl`

## Requirements
- R1: While reset is asserted, `gate_on`, `stop_by_tmax` and `stop_by_ipk` are 0. After reset the off-time lockout is already expired, so the first request may turn the switch on.
- R2: Each of `fb_req` and `ipk_trip` passes through a `SYNC_STAGES`-flop synchronizer (2 by default). With `en` high, the switch off and the lockout expired, a request that goes high turns `gate_on` high on the third rising clock edge after the change. It does not go high earlier.
- R3: With the switch on, a trip that goes high turns `gate_on` low on the third rising edge after the change. In that same cycle `stop_by_ipk` is 1 for exactly one cycle and `stop_by_tmax` is 0.
- R4: With no trip, `gate_on` stays high for exactly `ON_MAX_CYC` cycles, then goes low. In the first low cycle `stop_by_tmax` is 1 for one cycle and `stop_by_ipk` is 0.
- R5: After a turn-off caused by a trip or by the on-time limit, `gate_on` stays low for at least `OFF_MIN_CYC` cycles. If the request is held, it goes high again after exactly `OFF_MIN_CYC` low cycles.
- R6: A request that rises and falls again entirely inside the lockout is dropped. It does not turn the switch on after the lockout ends.
- R7: With the request held high and no trip, the output repeats a pattern of `ON_MAX_CYC` cycles high and `OFF_MIN_CYC` cycles low.
- R8: If the synchronized request and the synchronized trip are both high, the trip wins: the switch stays off. It turns on on the third edge after the trip is released.
- R9: With `en` low, `gate_on` is 0 in the same cycle, both flags are 0, and both counters are cleared. When `en` returns with the request held, `gate_on` rises on the first edge, with no lockout, and then gets a full `ON_MAX_CYC` on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Synchronous switching enable; when low, forces the gate off |
| fb_req | input | 1 | Asynchronous turn-on request (ORed voltage/current feedback) |
| ipk_trip | input | 1 | Asynchronous peak-current comparator trip |
| gate_on | output | 1 | Gate enable for the low-side switch |
| stop_by_tmax | output | 1 | One-cycle pulse: the on-time limit ended the pulse |
| stop_by_ipk | output | 1 | One-cycle pulse: the current trip ended the pulse |

## Verification
The assertions check the registered gate against the synchronized copies of the request and trip, not against the raw pins. They rely on `en` being synchronous to `clk`, and on the raw inputs meeting the synchronizer's requirement of being sampled cleanly at some edge. The bench drives every input on the falling clock edge. Each level it applies is held for at least one full cycle, except the deliberately short request inside the lockout. The assertion on the off-time bound applies only when `en` stayed high from the fall to the next rise, because a disable clears the lockout by design. The bench keeps those two cases in separate scenarios.

// File: rtl/hyst_pkg.sv
package hyst_pkg;

    // Registered switch state and the one-cycle termination flags
    typedef struct packed {
        logic gate;
        logic tmax_stop;
        logic ipk_stop;
    } gate_state_t;

endpackage

// File: rtl/hyst_sync.sv
module hyst_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/hyst_limit_timer.sv
// Saturating down-counter: clear has priority over load, load over decrement.
module hyst_limit_timer #(
    parameter int LOAD_VAL = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic dec,
    output logic zero
);

    localparam int CW = (LOAD_VAL < 1) ? 1 : $clog2(LOAD_VAL + 1);
    localparam logic [CW-1:0] LOAD_W = CW'(LOAD_VAL);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = LOAD_W;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    // R5: the count never wraps below zero while running
    a_r5_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && zero) |=> zero);

    // R9: a clear always empties the counter
    a_r9_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> zero);

endmodule

// File: rtl/hyst_gate_ctrl.sv
module hyst_gate_ctrl
    import hyst_pkg::*;
#(
    parameter int ON_MAX_CYC  = 1000,
    parameter int OFF_MIN_CYC = 126,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fb_req,
    input  logic ipk_trip,
    output logic gate_on,
    output logic stop_by_tmax,
    output logic stop_by_ipk
);

    localparam int ON_LOAD  = ON_MAX_CYC - 1;
    localparam int OFF_LOAD = OFF_MIN_CYC - 1;

    logic [1:0] raw_in, sync_out;
    logic       req_s, trip_s;
    logic       on_zero, off_zero;
    logic       set_ok, stop_trip, stop_tmax;
    logic       on_load, off_load;

    gate_state_t st_d, st_q;

    assign raw_in = {ipk_trip, fb_req};

    hyst_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    assign req_s  = sync_out[0];
    assign trip_s = sync_out[1];

    hyst_limit_timer #(.LOAD_VAL(ON_LOAD)) i_on_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!en),
        .load (on_load),
        .dec  (st_q.gate),
        .zero (on_zero)
    );

    hyst_limit_timer #(.LOAD_VAL(OFF_LOAD)) i_off_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!en),
        .load (off_load),
        .dec  (!st_q.gate),
        .zero (off_zero)
    );

    // Latch decode: reset (trip or timeout) beats set
    always_comb begin
        stop_trip = st_q.gate && trip_s;
        stop_tmax = st_q.gate && on_zero && !trip_s;
        set_ok    = !st_q.gate && req_s && off_zero && !trip_s;

        st_d           = st_q;
        st_d.tmax_stop = 1'b0;
        st_d.ipk_stop  = 1'b0;
        on_load        = 1'b0;
        off_load       = 1'b0;

        if (!en) begin
            st_d.gate = 1'b0;
        end else if (stop_trip) begin
            st_d.gate     = 1'b0;
            st_d.ipk_stop = 1'b1;
            off_load      = 1'b1;
        end else if (stop_tmax) begin
            st_d.gate      = 1'b0;
            st_d.tmax_stop = 1'b1;
            off_load       = 1'b1;
        end else if (set_ok) begin
            st_d.gate = 1'b1;
            on_load   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_on      = st_q.gate & en;
    assign stop_by_tmax = st_q.tmax_stop;
    assign stop_by_ipk  = st_q.ipk_stop;

    // ------------------------------------------------------------------
    // Assertion support: run-length counters observed from the latch
    // ------------------------------------------------------------------
    int unsigned on_run_q, off_run_q;
    logic        armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_run_q  <= 0;
            off_run_q <= 0;
            armed_q   <= 1'b0;
        end else begin
            on_run_q  <= st_q.gate ? on_run_q + 1 : 0;
            off_run_q <= st_q.gate ? 0 : ((off_run_q < 32'hFFFF) ? off_run_q + 1 : off_run_q);
            armed_q   <= !en ? 1'b0 : (st_q.gate ? 1'b1 : armed_q);
        end
    end

    // R2: a turn-on needs a synchronized request with enable high
    a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.gate) |-> ($past(req_s) && $past(en)));

    // R4: on-time never exceeds the limit
    a_r4_on_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gate |-> (on_run_q <= ON_MAX_CYC - 1));

    // R5: off-time between two enabled pulses respects the lockout
    a_r5_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.gate) && armed_q) |-> (off_run_q >= OFF_MIN_CYC));

    // R8: a synchronized trip always leaves the switch off next cycle
    a_r8_trip_wins: assert property (@(posedge clk) disable iff (!rst_n)
        trip_s |=> !st_q.gate);

    // R9: disable forces the latch low
    a_r9_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_q.gate);

    // R3: termination flags are exclusive
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.tmax_stop, st_q.ipk_stop}));

    // R4: the timeout flag coincides with a falling gate
    a_r4_flag_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmax_stop |-> $fell(st_q.gate));

endmodule

// File: tb/test_hyst_gate_ctrl.sv
`timescale 1ns/1ps
module test_hyst_gate_ctrl;

    localparam int TON  = 1000;
    localparam int TOFF = 126;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic fb_req = 1'b0;
    logic ipk_trip = 1'b0;
    logic gate_on, stop_by_tmax, stop_by_ipk;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    hyst_gate_ctrl #(
        .ON_MAX_CYC (TON),
        .OFF_MIN_CYC(TOFF),
        .SYNC_STAGES(2)
    ) i_hyst_gate_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .fb_req      (fb_req),
        .ipk_trip    (ipk_trip),
        .gate_on     (gate_on),
        .stop_by_tmax(stop_by_tmax),
        .stop_by_ipk (stop_by_ipk)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts samples (one per cycle) while gate_on equals lvl
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (gate_on == lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Turn on from idle: the gate rises at the third edge
    task automatic go_on();
        @(negedge clk) fb_req = 1'b1;
        cyc(3);
    endtask

    task automatic trip_off();
        @(negedge clk) fb_req = 1'b0; ipk_trip = 1'b1;
        cyc(3);
        ipk_trip = 1'b0;
        cyc(TOFF + 20);
    endtask

    task automatic t_reset();
        cyc(5);
        check(gate_on == 1'b0, "R1 gate in reset", gate_on, 0);
        check({stop_by_tmax, stop_by_ipk} == 2'b00, "R1 flags in reset",
              {stop_by_tmax, stop_by_ipk}, 0);
        rst_n = 1'b1;
        cyc(3);
    endtask

    task automatic t_turn_on();
        @(negedge clk) fb_req = 1'b1;
        cyc(2);
        check(gate_on == 1'b0, "R2 not before third edge", gate_on, 0);
        cyc(1);
        check(gate_on == 1'b1, "R2 on at third edge", gate_on, 1);
    endtask

    task automatic t_trip();
        fb_req = 1'b0;
        cyc(5);
        ipk_trip = 1'b1;
        cyc(2);
        check(gate_on == 1'b1, "R3 still on before third edge", gate_on, 1);
        cyc(1);
        check(gate_on == 1'b0, "R3 off at third edge", gate_on, 0);
        check(stop_by_ipk == 1'b1 && stop_by_tmax == 1'b0, "R3 trip flag",
              {stop_by_tmax, stop_by_ipk}, 1);
        ipk_trip = 1'b0;
        cyc(1);
        check(stop_by_ipk == 1'b0, "R3 flag one cycle", stop_by_ipk, 0);
        cyc(TOFF + 20);
    endtask

    task automatic t_timeout_train();
        int n;
        go_on();
        check(gate_on == 1'b1, "R4 turned on", gate_on, 1);
        run_len(1'b1, n);
        check(n == TON, "R4 on length", n, TON);
        check(stop_by_tmax == 1'b1 && stop_by_ipk == 1'b0, "R4 timeout flag",
              {stop_by_tmax, stop_by_ipk}, 2);
        run_len(1'b0, n);
        check(n == TOFF, "R7 off length with held request", n, TOFF);
        run_len(1'b1, n);
        check(n == TON, "R7 second on length", n, TON);
        fb_req = 1'b0;
        cyc(TOFF + 20);
    endtask

    task automatic t_trip_lockout();
        int n;
        go_on();
        check(gate_on == 1'b1, "R5 turned on", gate_on, 1);
        ipk_trip = 1'b1;
        cyc(3);
        check(gate_on == 1'b0, "R5 trip off", gate_on, 0);
        ipk_trip = 1'b0;
        run_len(1'b0, n);
        check(n == TOFF, "R5 lockout after trip", n, TOFF);
        trip_off();
    endtask

    task automatic t_dropped_request();
        go_on();
        trip_off();
        go_on();
        fb_req = 1'b0;
        ipk_trip = 1'b1;
        cyc(3);
        ipk_trip = 1'b0;
        check(gate_on == 1'b0, "R6 off before pulse", gate_on, 0);
        cyc(20);
        fb_req = 1'b1;
        cyc(10);
        fb_req = 1'b0;
        cyc(TOFF + 50);
        check(gate_on == 1'b0, "R6 short request dropped", gate_on, 0);
    endtask

    task automatic t_both_high();
        @(negedge clk) fb_req = 1'b1; ipk_trip = 1'b1;
        cyc(10);
        check(gate_on == 1'b0, "R8 trip beats request", gate_on, 0);
        ipk_trip = 1'b0;
        cyc(2);
        check(gate_on == 1'b0, "R8 off until third edge", gate_on, 0);
        cyc(1);
        check(gate_on == 1'b1, "R8 on after trip release", gate_on, 1);
        trip_off();
    endtask

    task automatic t_enable();
        int n;
        go_on();
        check(gate_on == 1'b1, "R9 on before disable", gate_on, 1);
        @(negedge clk) en = 1'b0;
        #1;
        check(gate_on == 1'b0, "R9 gate low at once", gate_on, 0);
        cyc(5);
        check(gate_on == 1'b0 && stop_by_tmax == 1'b0 && stop_by_ipk == 1'b0,
              "R9 held off while disabled", {gate_on, stop_by_tmax, stop_by_ipk}, 0);
        en = 1'b1;
        cyc(1);
        check(gate_on == 1'b1, "R9 no lockout after re-enable", gate_on, 1);
        run_len(1'b1, n);
        check(n == TON, "R9 full on-time after clear", n, TON);
        fb_req = 1'b0;
        cyc(TOFF + 20);
    endtask

    initial begin
        t_reset();
        t_turn_on();
        t_trip();
        t_timeout_train();
        t_trip_lockout();
        t_dropped_request();
        t_both_high();
        t_enable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500us;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule